// File: doc/BRIEF.md
# Configurable Serial Burst Capture Transmitter

This block is a transmit-only serial master. It pushes a burst of sample words to an SPI-style receiver. When the block is enabled and idle, a one-cycle trigger captures sixteen parallel 24-bit samples and an 8-bit configuration byte. The block then sends the selected words, MSB first. Each word is sign-extended to 32 bits before it is sent.

The block drives three lines: a generated serial clock, a data line and a package select line. The serial clock is the system clock divided by two or by four. Data changes on the falling edge of the serial clock, and the receiver samples it on the rising edge.

The configuration byte chooses:
- the clock rate;
- whether the frame runs continuously or is cut into packages with idle gaps between them;
- the package length when gaps are used;
- one of three word subsets, each sent in a fixed order;
- the select polarity.

The configuration byte is captured at the start of the frame and held for the whole frame.

Top module: `burst_capture_tx`

## Requirements
- R1: After reset and whenever no frame is running, `sclk_o` and `sd_o` are high. `sel_o` sits at its inactive level, which is high right after reset.
- R2: A frame starts only when `trigger_i` is high on a clock edge while `enable_i` is high and no frame is running. A trigger while `enable_i` is low is ignored. A trigger during a frame is ignored.
- R3: Configuration bit 0 sets the serial clock period. 0 gives 2 system clocks per bit and 1 gives 4 system clocks per bit. Each bit period starts with the low half of the serial clock.
- R4: `sd_o` changes only on a falling edge of `sclk_o` and holds across the rising edge. Each word is sent from bit 31 down to bit 0.
- R5: Each 24-bit sample is sent as a 32-bit word whose top 8 bits copy sample bit 23.
- R6: Sample i occupies `samples_i[24i+23:24i]`. Configuration bits [4:3] select the words. 00 and 11 send samples 0..15 in ascending order. 01 sends samples 0..6. 10 sends samples 7..15.
- R7: With configuration bit 2 clear, all bits of the frame follow each other with no pause, and the select line is active for the whole frame. Bit 1 then has no effect.
- R8: With configuration bit 2 set, packages are 32 bits (bit 1 = 0) or 8 bits (bit 1 = 1). Between packages there are 7 serial-clock periods with the select line inactive and the clock and data lines high.
- R9: Configuration bit 5 sets select polarity. With 0, the select line is low during packages and high otherwise. With 1, the opposite applies.
- R10: The configuration used for a frame is the value present at the triggering edge. Later changes take effect only for the next frame. Configuration bits [7:6] have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Allows frames to start |
| trigger_i | input | 1 | Capture trigger, one cycle |
| cfg_i | input | 8 | Configuration byte |
| samples_i | input | 384 | Sixteen 24-bit samples, sample i at bits [24i+23:24i] |
| sclk_o | output | 1 | Generated serial clock, idles high |
| sd_o | output | 1 | Serial data, idles high |
| sel_o | output | 1 | Package select, polarity set by configuration |

## Verification
Errors in the word pointer or the word counter show up at the ports in the first wrong word. A shifted or truncated sequence of sample values appears, or bits remain after the frame should have ended. A fault in the bit counter or the package-end decode makes the spacing between falling edges wrong at the first package boundary. It also changes how many cycles the select line is active. A wrong divider count or configuration snapshot changes the serial clock period from the second bit on. The scoreboard therefore compares every received bit, its edge spacing and the select level at the moment it is sampled.

// File: rtl/btx_pkg.sv
package btx_pkg;
  localparam int NUM_WORDS = 16;
  localparam int IV_COUNT  = 7;   // current/voltage subset: words 0..6
  localparam int PWR_FIRST = 7;   // power subset starts here
  localparam int PWR_COUNT = 9;   // power subset: words 7..15

  // configuration bit positions
  localparam int B_SLOW  = 0;
  localparam int B_SIZE8 = 1;
  localparam int B_GAP   = 2;
  localparam int B_SETLO = 3;
  localparam int B_SETHI = 4;
  localparam int B_POL   = 5;
  localparam int CFG_KEEP = 6;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_GAP} state_t;
endpackage

// File: rtl/btx_rst_sync.sv
module btx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/btx_clk_div.sv
module btx_clk_div #(
  parameter int HALF_FAST = 1,
  parameter int HALF_SLOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic slow_i,
  output logic tick_o
);
  localparam int CW = (HALF_SLOW > 1) ? $clog2(HALF_SLOW + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim    = slow_i ? CW'(HALF_SLOW - 1) : CW'(HALF_FAST - 1);
    tick_o = run_i && (cnt_q == lim);
    cnt_d  = (!run_i || tick_o) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/btx_word_sel.sv
module btx_word_sel #(
  parameter int SAMPLE_W = 24,
  parameter int WORD_W   = 32,
  parameter int N        = 16
) (
  input  logic [N*SAMPLE_W-1:0]  samples_i,
  input  logic [$clog2(N)-1:0]   idx_i,
  output logic [WORD_W-1:0]      word_o
);
  localparam int EXT_W = WORD_W - SAMPLE_W;

  logic [SAMPLE_W-1:0] lane [N];
  logic [SAMPLE_W-1:0] pick;

  for (genvar g = 0; g < N; g++) begin : g_lane
    assign lane[g] = samples_i[g*SAMPLE_W +: SAMPLE_W];
  end

  assign pick   = lane[idx_i];
  assign word_o = {{EXT_W{pick[SAMPLE_W-1]}}, pick};
endmodule

// File: rtl/burst_capture_tx.sv
module burst_capture_tx
  import btx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int WORD_W      = 32,
  parameter int PKG_W       = 8,
  parameter int GAP_PERIODS = 7,
  parameter int HALF_FAST   = 1,
  parameter int HALF_SLOW   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable_i,
  input  logic                            trigger_i,
  input  logic [7:0]                      cfg_i,
  input  logic [NUM_WORDS*SAMPLE_W-1:0]   samples_i,
  output logic                            sclk_o,
  output logic                            sd_o,
  output logic                            sel_o
);
  localparam int IDX_W  = $clog2(NUM_WORDS);
  localparam int CNT_W  = $clog2(NUM_WORDS + 1);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int PKGB   = $clog2(PKG_W);
  localparam int GAP_HT = 2 * GAP_PERIODS;
  localparam int GAP_W  = $clog2(GAP_HT);

  logic rst_sync_n;
  logic tick;
  logic cfg_unused;

  state_t                         state_q, state_d;
  logic [CFG_KEEP-1:0]            cfg_q, cfg_d;
  logic [NUM_WORDS*SAMPLE_W-1:0]  samp_q, samp_d;
  logic [WORD_W-1:0]              shreg_q, shreg_d;
  logic [BIT_W-1:0]               bit_q, bit_d;
  logic [IDX_W-1:0]               ptr_q, ptr_d, ptr_nx, start_idx;
  logic [CNT_W-1:0]               left_q, left_d, start_cnt;
  logic                           half_q, half_d;
  logic [GAP_W-1:0]               gap_q, gap_d;
  logic [WORD_W-1:0]              first_word, next_word;
  logic                           word_end, last_bit, pkg_end;

  assign cfg_unused = ^cfg_i[7:6];

  btx_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  btx_clk_div #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_div (
    .clk(clk), .rst_n(rst_sync_n),
    .run_i(state_q != ST_IDLE), .slow_i(cfg_q[B_SLOW]), .tick_o(tick)
  );

  // subset decode from the live configuration (used only at the trigger)
  always_comb begin
    unique case (cfg_i[B_SETHI:B_SETLO])
      2'b01:   begin start_idx = '0;               start_cnt = CNT_W'(IV_COUNT);  end
      2'b10:   begin start_idx = IDX_W'(PWR_FIRST); start_cnt = CNT_W'(PWR_COUNT); end
      default: begin start_idx = '0;               start_cnt = CNT_W'(NUM_WORDS); end
    endcase
  end

  assign ptr_nx = ptr_q + IDX_W'(1);

  btx_word_sel #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .N(NUM_WORDS)) u_first (
    .samples_i(samples_i), .idx_i(start_idx), .word_o(first_word)
  );

  btx_word_sel #(.SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .N(NUM_WORDS)) u_next (
    .samples_i(samp_q), .idx_i(ptr_nx), .word_o(next_word)
  );

  assign word_end = (bit_q == BIT_W'(WORD_W - 1));
  assign last_bit = word_end && (left_q == CNT_W'(1));
  assign pkg_end  = cfg_q[B_GAP] &&
                    (cfg_q[B_SIZE8] ? (bit_q[PKGB-1:0] == PKGB'(PKG_W - 1)) : word_end);

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    samp_d  = samp_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    ptr_d   = ptr_q;
    left_d  = left_q;
    half_d  = half_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: begin
        cfg_d = cfg_i[CFG_KEEP-1:0];
        if (enable_i && trigger_i) begin
          state_d = ST_SEND;
          samp_d  = samples_i;
          shreg_d = first_word;
          bit_d   = '0;
          ptr_d   = start_idx;
          left_d  = start_cnt;
          half_d  = 1'b0;
        end
      end
      ST_SEND: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
          end else begin
            half_d  = 1'b0;
            shreg_d = shreg_q << 1;
            bit_d   = word_end ? '0 : bit_q + BIT_W'(1);
            if (last_bit) begin
              state_d = ST_IDLE;
            end else begin
              if (word_end) begin
                left_d  = left_q - CNT_W'(1);
                ptr_d   = ptr_nx;
                shreg_d = next_word;
              end
              if (pkg_end) begin
                state_d = ST_GAP;
                gap_d   = '0;
              end
            end
          end
        end
      end
      ST_GAP: begin
        if (tick) begin
          if (gap_q == GAP_W'(GAP_HT - 1)) begin
            state_d = ST_SEND;
            half_d  = 1'b0;
          end else begin
            gap_d = gap_q + GAP_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      samp_q  <= '0;
      shreg_q <= '0;
      bit_q   <= '0;
      ptr_q   <= '0;
      left_q  <= '0;
      half_q  <= 1'b0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
      samp_q  <= samp_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      ptr_q   <= ptr_d;
      left_q  <= left_d;
      half_q  <= half_d;
      gap_q   <= gap_d;
    end
  end

  assign sclk_o = !(state_q == ST_SEND && !half_q);
  assign sd_o   = (state_q == ST_SEND) ? shreg_q[WORD_W-1] : 1'b1;
  assign sel_o  = (state_q == ST_SEND) ? cfg_q[B_POL] : !cfg_q[B_POL];
endmodule

// File: rtl/btx_checker.sv
module btx_checker
  import btx_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                enable_i,
  input logic                sclk_o,
  input logic                sd_o,
  input logic                sel_o,
  input state_t              state_q,
  input logic [CFG_KEEP-1:0] cfg_q
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE |-> (sclk_o && sd_o));

  // R2
  disabled_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !enable_i) |=> state_q == ST_IDLE);

  // R4
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_SEND && !$fell(sclk_o)) |-> $stable(sd_o));

  // R8
  gap_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_GAP |-> (sclk_o && sd_o && (sel_o != cfg_q[B_POL])));

  // R9
  fall_inside_pkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_o) |-> (sel_o == cfg_q[B_POL]));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(cfg_q));
endmodule

bind burst_capture_tx btx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
  .sclk_o(sclk_o), .sd_o(sd_o), .sel_o(sel_o),
  .state_q(state_q), .cfg_q(cfg_q)
);

// File: tb/tb_burst_capture_tx.sv
module tb_burst_capture_tx;
  localparam int NW = 16;
  localparam int SW = 24;
  localparam int WD_LIMIT = 150000;

  typedef struct { logic b; int delta; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable_i = 1'b0;
  logic trigger_i = 1'b0;
  logic [7:0] cfg_i = 8'h00;
  logic [NW*SW-1:0] samples_i = '0;
  logic sclk_o, sd_o, sel_o;

  burst_capture_tx dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .trigger_i(trigger_i),
    .cfg_i(cfg_i), .samples_i(samples_i),
    .sclk_o(sclk_o), .sd_o(sd_o), .sel_o(sel_o)
  );

  always #10 clk = ~clk;

  item_t q[$];
  int total = 0, bad = 0;
  int cyc = 0, last_fall = 0, last_delta = 0, act_cyc = 0, rise_cnt = 0;
  logic prev_sclk = 1'b1;
  logic cur_pol = 1'b0;
  logic mon_on = 1'b0;
  string cur_tag = "";

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, cur_tag, act, exp);
    end
  endtask

  // monitor: pops expected bits at each serial clock rising edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (mon_on) begin
      if (sel_o == cur_pol) act_cyc++;
      if (prev_sclk && !sclk_o) begin
        last_delta = cyc - last_fall;
        last_fall  = cyc;
      end
      if (!prev_sclk && sclk_o) begin
        rise_cnt++;
        if (q.size() == 0) begin
          check(1'b0, "R2 unexpected bit", 1, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(sd_o == it.b, "R4 R5 R6 data bit", int'(sd_o), int'(it.b));
          check(sel_o == cur_pol, "R9 select level", int'(sel_o), int'(cur_pol));
          if (it.delta != 0)
            check(last_delta == it.delta, "R3 R8 edge spacing", last_delta, it.delta);
        end
      end
    end
    prev_sclk = sclk_o;
  end

  function automatic logic [SW-1:0] mk_sample(input int seed, input int i);
    logic [SW-1:0] v;
    v = SW'(seed * 40503 + i * 2654435 + 777);
    v[SW-1] = logic'(i[0] ^ seed[0]);
    return v;
  endfunction

  task automatic run_frame(input logic [7:0] c, input int seed, input bit poke, input string tag);
    int h, first, cnt, nbits;
    logic [31:0] ext;
    logic [SW-1:0] v;
    cur_tag = tag;
    h = c[0] ? 2 : 1;
    case (c[4:3])
      2'b01:   begin first = 0; cnt = 7; end
      2'b10:   begin first = 7; cnt = 9; end
      default: begin first = 0; cnt = 16; end
    endcase
    nbits = 0;
    for (int w = 0; w < cnt; w++) begin
      v = mk_sample(seed, first + w);
      ext = {{8{v[SW-1]}}, v};
      for (int b = 31; b >= 0; b--) begin
        item_t it;
        bit is_first, bound;
        is_first = (w == 0 && b == 31);
        bound = c[2] && !is_first && (c[1] ? (b % 8 == 7) : (b == 31));
        it.b = ext[b];
        it.delta = is_first ? 0 : (bound ? 16 * h : 2 * h);
        q.push_back(it);
        nbits++;
      end
    end
    for (int i = 0; i < NW; i++) samples_i[i*SW +: SW] = mk_sample(seed, i);
    cfg_i = c;
    cur_pol = c[5];
    @(negedge clk);
    act_cyc = 0;
    trigger_i = 1'b1;
    @(negedge clk);
    trigger_i = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      // R10 / R2: new configuration and a second trigger mid-frame
      cfg_i = {2'b11, c[5], ~c[4:3], ~c[2:0]};
      for (int i = 0; i < NW; i++) samples_i[i*SW +: SW] = ~mk_sample(seed, i);
      trigger_i = 1'b1;
      @(negedge clk);
      trigger_i = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sclk_o == 1'b1, "R1 idle clock", int'(sclk_o), 1);
    check(sd_o == 1'b1, "R1 idle data", int'(sd_o), 1);
    check(sel_o == !cur_pol, "R1 R9 idle select", int'(sel_o), int'(!cur_pol));
    check(act_cyc == nbits * 2 * h, "R7 R8 select window", act_cyc, nbits * 2 * h);
    cfg_i = {2'b00, c[5], 5'b0};
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_tag = "reset";
    // R1: lines after reset
    check(sclk_o == 1'b1, "R1 reset clock", int'(sclk_o), 1);
    check(sd_o == 1'b1, "R1 reset data", int'(sd_o), 1);
    check(sel_o == 1'b1, "R1 reset select", int'(sel_o), 1);
    mon_on = 1'b1;

    // R2: trigger with enable low is ignored
    cur_tag = "disabled";
    trigger_i = 1'b1;
    @(negedge clk);
    trigger_i = 1'b0;
    repeat (50) @(negedge clk);
    check(rise_cnt == 0, "R2 no frame while disabled", rise_cnt, 0);
    check(sel_o == 1'b1, "R2 select stays inactive", int'(sel_o), 1);

    enable_i = 1'b1;
    run_frame(8'h00, 3, 1'b0, "all fast continuous");          // R3 R5 R6 R7
    run_frame(8'h0D, 8, 1'b0, "iv slow gap32");                // R3 R6 R8
    run_frame(8'h36, 5, 1'b0, "power fast gap8 pol1");         // R6 R8 R9
    run_frame(8'hDA, 12, 1'b0, "set11 reserved size8 nogap");  // R6 R7 R10
    run_frame(8'h14, 21, 1'b1, "R10 busy trigger and cfg change"); // R2 R10
    run_frame(8'h27, 30, 1'b0, "all slow gap8 pol1");          // R3 R8 R9

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule